// File: doc/BRIEF.md
# Thermal Printhead Line Sequencer

This block prints one dot line on a thermal printhead for each start pulse. It reads the pixel bits of the line from an internal line buffer and shifts them out serially against a shift clock. In latched mode it then pulses a latch so that the head holds the line. After that it fires between one and four strobe groups, one after another, to heat the dots. A programmable line period, counted in ticks of a prescaled timebase, sets the minimum time from one accepted start to the next. The busy output stays high until both the period has elapsed and the last strobe has ended, and start pulses that arrive while busy is high are dropped.

Software or a DMA engine fills the line buffer through a byte-wide write port. Pixel i of the line is bit (i mod 8) of byte i/8, and pixels leave the block in index order. In split mode the head takes the shifted data without a latch. The data must then stay put until the strobes are done, so the buffer refuses writes until the line has finished. In latched mode the buffer reopens as soon as the latch pulse has ended, so the next line can be loaded while the current line is still being strobed. The configuration inputs must be held stable while busy is high.

Top module: `thermal_line_seq`

## Requirements
- R1: After reset, ph_sdata, ph_sclk, ph_latch, ph_strobe and busy are all 0, and load_ok is 1.
- R2: Take L = cfg_len + 1 (1 to 2048) and D = cfg_div + 1. For each pixel index i from 0 to L-1 in order, ph_sclk is low for D cycles and then high for D cycles, and ph_sdata holds bit (i mod 8) of buffer byte i/8 for the whole bit time. The first low half starts on the clock edge that accepts start.
- R3: With cfg_split = 0, exactly one latch pulse follows the shift. It rises on the edge where the last shift-clock high half ends, it lasts cfg_latch_w x (cfg_prescale + 1) cycles, and ph_sclk stays low and no strobe is high while it lasts.
- R4: With N = cfg_groups + 1, strobe bits 0 to N-1 fire once each, in rising index order. Each lasts cfg_strobe_w x (cfg_prescale + 1) cycles, and each one rises on the edge where the previous one falls. Strobe 0 rises on the edge where the latch falls. At most one strobe bit is high at a time, and bits N and above stay low.
- R5: With cfg_split = 1, no latch pulse occurs, and strobe 0 rises on the edge where the last shift-clock high half ends.
- R6: busy rises on the edge that accepts start. It stays high for max(S, cfg_period x (cfg_prescale + 1)) cycles, where S is the length of the shift, latch and strobe sequence in cycles.
- R7: A start pulse while busy is high is ignored: it neither lengthens busy nor begins another line.
- R8: A buffer write takes effect only when load_ok is 1. load_ok is 1 when idle, and in latched mode also from the end of the latch until the line ends. Writes at other times leave the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 8 | Buffer byte address |
| wr_data | input | 8 | Buffer byte data, bit k is pixel 8*addr+k |
| start | input | 1 | Begin a line when idle |
| cfg_len | input | 11 | Pixels per line minus one |
| cfg_div | input | 8 | Shift clock half period minus one, in cycles |
| cfg_prescale | input | 16 | Timebase tick length minus one, in cycles |
| cfg_latch_w | input | 16 | Latch width in ticks, at least 1 |
| cfg_strobe_w | input | 16 | Width of each strobe in ticks, at least 1 |
| cfg_period | input | 16 | Line period in ticks, at least 1 |
| cfg_groups | input | 2 | Strobe groups per line minus one |
| cfg_split | input | 1 | 1 selects latchless split mode |
| ph_sdata | output | 1 | Serial pixel data |
| ph_sclk | output | 1 | Shift clock |
| ph_latch | output | 1 | Latch pulse |
| ph_strobe | output | 4 | Strobe group enables |
| busy | output | 1 | Line in progress, start refused |
| load_ok | output | 1 | Buffer writes accepted |

## Verification
The bench goes after the ends of the line: a one-pixel line and a full 2048-pixel line. A design with an off-by-one bit counter would shift one pixel too many or too few, and a wrong byte or bit split of the index would put the pixels in the wrong order. It uses sequences both shorter and longer than the period. A design that counted only the period, or only the sequence, would drop busy early in one of the two cases and cut off strobes or admit starts too soon. It writes to the buffer during the shift, and during the strobes in both modes, then prints the same line again. A design that ignored the write gate would alter data mid-line or refuse a legal early load, and the reprinted line shows which. It also sends a start while busy is high, which a faulty design would take as a restart that stretches busy.

// File: rtl/thermal_line_seq.sv
module thermal_line_seq #(
  parameter int MAX_PIX = 2048,
  parameter int DIV_W   = 8,
  parameter int TICK_W  = 16,
  parameter int NSTB    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(MAX_PIX/8)-1:0] wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic                        start,
  input  logic [$clog2(MAX_PIX)-1:0]  cfg_len,
  input  logic [DIV_W-1:0]            cfg_div,
  input  logic [TICK_W-1:0]           cfg_prescale,
  input  logic [TICK_W-1:0]           cfg_latch_w,
  input  logic [TICK_W-1:0]           cfg_strobe_w,
  input  logic [TICK_W-1:0]           cfg_period,
  input  logic [(NSTB>1?$clog2(NSTB):1)-1:0] cfg_groups,
  input  logic                        cfg_split,
  output logic                        ph_sdata,
  output logic                        ph_sclk,
  output logic                        ph_latch,
  output logic [NSTB-1:0]             ph_strobe,
  output logic                        busy,
  output logic                        load_ok
);
  localparam int BYTES = MAX_PIX / 8;
  localparam int PW    = $clog2(MAX_PIX);
  localparam int GW    = (NSTB > 1) ? $clog2(NSTB) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_LATCH, S_STROBE, S_WAIT} st_t;
  st_t st;

  logic [7:0]        line_mem [BYTES];
  logic [PW-1:0]     bit_idx, nxt_idx;
  logic [DIV_W-1:0]  div_cnt;
  logic [TICK_W-1:0] per_ps, per_cnt, ph_ps, ph_cnt, ph_w;
  logic [GW-1:0]     grp;
  logic              per_done, split_r;
  logic              nxt_bit, first_bit, div_end, last_bit, last_grp;
  logic              per_term, per_hit, ph_end, ph_roll;

  assign load_ok   = (st == S_IDLE) || (!split_r && (st == S_STROBE || st == S_WAIT));
  assign nxt_idx   = bit_idx + PW'(1);
  assign nxt_bit   = line_mem[nxt_idx[PW-1:3]][nxt_idx[2:0]];
  assign first_bit = line_mem[0][0];
  assign div_end   = div_cnt == cfg_div;
  assign last_bit  = bit_idx == cfg_len;
  assign last_grp  = grp == cfg_groups;
  assign per_term  = (per_cnt == cfg_period - TICK_W'(1)) && (per_ps == cfg_prescale);
  assign per_hit   = per_done || per_term;
  assign ph_w      = (st == S_LATCH) ? cfg_latch_w : cfg_strobe_w;
  assign ph_roll   = ph_ps == cfg_prescale;
  assign ph_end    = (ph_cnt == ph_w - TICK_W'(1)) && ph_roll;

  always_ff @(posedge clk)
    if (wr_en && load_ok) line_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_ps <= '0; per_cnt <= '0; per_done <= 1'b0;
    end else if (st == S_IDLE && start) begin
      per_ps <= '0; per_cnt <= '0; per_done <= 1'b0;
    end else if (busy && !per_done) begin
      if (per_term) per_done <= 1'b1;
      else if (per_ps == cfg_prescale) begin
        per_ps <= '0; per_cnt <= per_cnt + TICK_W'(1);
      end else per_ps <= per_ps + TICK_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; split_r <= 1'b0;
      bit_idx <= '0; div_cnt <= '0; grp <= '0;
      ph_ps <= '0; ph_cnt <= '0;
      ph_sdata <= 1'b0; ph_sclk <= 1'b0; ph_latch <= 1'b0; ph_strobe <= '0;
    end else begin
      if (st == S_LATCH || st == S_STROBE) begin
        if (ph_end) begin
          ph_ps <= '0; ph_cnt <= '0;
        end else if (ph_roll) begin
          ph_ps <= '0; ph_cnt <= ph_cnt + TICK_W'(1);
        end else ph_ps <= ph_ps + TICK_W'(1);
      end else begin
        ph_ps <= '0; ph_cnt <= '0;
      end
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_SHIFT; busy <= 1'b1; split_r <= cfg_split;
            bit_idx <= '0; div_cnt <= '0; ph_sclk <= 1'b0; ph_sdata <= first_bit;
          end
        S_SHIFT:
          if (!div_end) div_cnt <= div_cnt + DIV_W'(1);
          else begin
            div_cnt <= '0;
            if (!ph_sclk) ph_sclk <= 1'b1;
            else begin
              ph_sclk <= 1'b0;
              if (last_bit) begin
                ph_sdata <= 1'b0; grp <= '0;
                if (split_r) begin
                  st <= S_STROBE; ph_strobe <= NSTB'(1);
                end else begin
                  st <= S_LATCH; ph_latch <= 1'b1;
                end
              end else begin
                bit_idx <= nxt_idx; ph_sdata <= nxt_bit;
              end
            end
          end
        S_LATCH:
          if (ph_end) begin
            ph_latch <= 1'b0; st <= S_STROBE; ph_strobe <= NSTB'(1);
          end
        S_STROBE:
          if (ph_end) begin
            if (last_grp) begin
              ph_strobe <= '0;
              if (per_hit) begin st <= S_IDLE; busy <= 1'b0; end
              else st <= S_WAIT;
            end else begin
              grp <= grp + GW'(1); ph_strobe <= ph_strobe << 1;
            end
          end
        S_WAIT:
          if (per_hit) begin st <= S_IDLE; busy <= 1'b0; end
        default: st <= S_IDLE;
      endcase
    end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_strobe));
  p_latch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_latch |-> (!ph_sclk && ph_strobe == '0));
  p_split_nolatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && split_r) |-> !ph_latch);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ph_strobe == '0 && !ph_latch && !ph_sclk));
  p_latch_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_latch |-> !load_ok);
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && ph_sclk) |=> busy);
endmodule

// File: tb/thermal_line_seq_bench.sv
module thermal_line_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, cfg_split = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, cfg_div = '0;
  logic [10:0] cfg_len = '0;
  logic [15:0] cfg_prescale = '0, cfg_latch_w = 16'd1, cfg_strobe_w = 16'd1, cfg_period = 16'd1;
  logic [1:0] cfg_groups = '0;
  logic ph_sdata, ph_sclk, ph_latch, busy, load_ok;
  logic [3:0] ph_strobe;

  thermal_line_seq u_thermal_line_seq (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [256];
  bit cap [2048];
  int L, D, PS, LW, SW, NG, SP, PER, MODE, WA, WD;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic write_byte(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    ref_mem[a] = 8'(d);
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_line();
    int cyc = 0, nb = 0, hrun = 0, bad_half = 0, lat_cnt = 0, lat_rises = 0, bad_q = 0;
    int multi = 0, next_g = 0, bad_order = 0, bad_link = 0, busy_cnt = 0, mism = 0;
    int scnt [4];
    int S, M, pend = 0, wd_exp = 0;
    bit done = 0, p_sclk = 0, p_latch = 0, p_busy = 0;
    logic [3:0] p_stb = '0;
    for (int g = 0; g < 4; g++) scnt[g] = 0;
    S = L * 2 * (D + 1) + (SP ? 0 : LW * (PS + 1)) + NG * SW * (PS + 1);
    M = maxi(S, PER * (PS + 1));
    @(negedge clk);
    cfg_len = 11'(L - 1); cfg_div = 8'(D); cfg_prescale = 16'(PS); cfg_latch_w = 16'(LW);
    cfg_strobe_w = 16'(SW); cfg_groups = 2'(NG - 1); cfg_split = SP[0]; cfg_period = 16'(PER);
    start = 1'b1;
    @(negedge clk);
    while (!done && cyc < 100000) begin
      start = 1'b0; wr_en = 1'b0;
      if (busy) busy_cnt++;
      if (ph_sclk && !p_sclk) begin
        if (nb < 2048) cap[nb] = ph_sdata;
        nb++;
      end
      if (ph_sclk) hrun++;
      if (!ph_sclk && p_sclk) begin
        if (hrun != D + 1) bad_half++;
        hrun = 0;
      end
      if (ph_latch) begin
        lat_cnt++;
        if (ph_sclk || ph_strobe != 0) bad_q++;
        if (!p_latch) begin
          lat_rises++;
          if (!p_sclk) bad_q++;
        end
      end
      if ($countones(ph_strobe) > 1) multi++;
      for (int g = 0; g < 4; g++) begin
        if (ph_strobe[g]) scnt[g]++;
        if (ph_strobe[g] && !p_stb[g]) begin
          if (g != next_g) bad_order++;
          next_g++;
          if (g == 0) begin
            if (SP ? !p_sclk : !p_latch) bad_link++;
          end else if (!p_stb[g-1]) bad_link++;
        end
      end
      if (p_busy && !busy) done = 1;
      if (MODE == 1 && cyc == 1) begin
        chk(load_ok == 1'b0, "R8 load_ok during shift", load_ok, 0);
        wr_en = 1'b1; wr_addr = 8'(WA); wr_data = 8'(WD);
      end
      if (MODE == 2 && ph_strobe[0] && !p_stb[0]) begin
        chk(load_ok == !SP[0], "R8 load_ok during strobe", load_ok, !SP[0]);
        wr_en = 1'b1; wr_addr = 8'(WA); wr_data = 8'(WD);
        if (!SP) begin pend = 1; wd_exp = WD; end
      end
      if (MODE == 3 && cyc == 2) start = 1'b1;
      p_sclk = ph_sclk; p_latch = ph_latch; p_stb = ph_strobe; p_busy = busy;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; wr_en = 1'b0;
    chk(done, "R6 line completes", cyc, M);
    chk(nb == L, "R2 shift clock count", nb, L);
    for (int i = 0; i < L && i < nb; i++)
      if (cap[i] != ref_mem[i/8][i%8]) mism++;
    chk(mism == 0, "R2 pixel data mismatches", mism, 0);
    chk(bad_half == 0, "R2 shift clock high half", bad_half, 0);
    if (SP) chk(lat_rises == 0, "R5 no latch in split mode", lat_rises, 0);
    else begin
      chk(lat_rises == 1, "R3 latch pulse count", lat_rises, 1);
      chk(lat_cnt == LW * (PS + 1), "R3 latch width", lat_cnt, LW * (PS + 1));
      chk(bad_q == 0, "R3 latch placement", bad_q, 0);
    end
    for (int g = 0; g < 4; g++)
      chk(scnt[g] == ((g < NG) ? SW * (PS + 1) : 0), "R4 strobe width", scnt[g],
          (g < NG) ? SW * (PS + 1) : 0);
    chk(multi == 0 && bad_order == 0 && next_g == NG, "R4 strobe order", next_g, NG);
    chk(bad_link == 0, SP ? "R5 strobe start" : "R4 strobe handoff", bad_link, 0);
    chk(busy_cnt == M, "R6 busy length", busy_cnt, M);
    if (MODE == 3) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && ph_sclk == 1'b0, "R7 start while busy ignored", busy, 0);
    end
    if (pend) ref_mem[WA] = 8'(wd_exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ph_sdata == 0 && ph_sclk == 0 && ph_latch == 0, "R1 reset outputs", ph_latch, 0);
    chk(ph_strobe == 0 && busy == 0, "R1 reset strobe busy", busy, 0);
    chk(load_ok == 1'b1, "R1 reset load_ok", load_ok, 1);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) write_byte(a, int'($urandom_range(0, 255)));

    L = 1; D = 0; PS = 0; LW = 1; SW = 1; NG = 1; SP = 0; PER = 30; MODE = 0; run_line();
    L = 2048; D = 0; PS = 0; LW = 2; SW = 3; NG = 4; SP = 0; PER = 10; MODE = 0; run_line();
    L = 20; D = 1; PS = 1; LW = 2; SW = 2; NG = 4; SP = 1; PER = 200; MODE = 3; run_line();
    L = 16; D = 0; PS = 0; LW = 1; SW = 2; NG = 2; SP = 0; PER = 5; MODE = 1; WA = 0;
    WD = ~ref_mem[0]; run_line();
    MODE = 0; run_line();
    MODE = 2; WA = 1; WD = ~ref_mem[1]; run_line();
    MODE = 0; run_line();
    SP = 1; MODE = 2; WA = 0; WD = ~ref_mem[0]; run_line();
    MODE = 0; run_line();

    for (int n = 0; n < 30; n++) begin
      int s0;
      L = $urandom_range(1, 64); D = $urandom_range(0, 3); PS = $urandom_range(0, 3);
      LW = $urandom_range(1, 4); SW = $urandom_range(1, 5); NG = $urandom_range(1, 4);
      SP = $urandom_range(0, 1); MODE = $urandom_range(0, 3);
      WA = $urandom_range(0, (L - 1) / 8); WD = $urandom_range(0, 255);
      s0 = L * 2 * (D + 1) + (SP ? 0 : LW * (PS + 1)) + NG * SW * (PS + 1);
      PER = $urandom_range(1, s0 / (PS + 1) + 20);
      if (n % 5 == 0) write_byte(WA, int'($urandom_range(0, 255)));
      run_line();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule